// File: doc/BRIEF.md
# Writeback Uncorrectable-Error Marking Unit

This unit sits between the first-level data cache eviction logic and the write port of the second-level cache. Each beat carries one 64-bit doubleword and its 8 check bits, and a cache line is a fixed burst of eight beats. The unit classifies every beat as clean, single-bit correctable, raw uncorrectable, or already marked as uncorrectable, and forwards a word that is safe to store. A correctable word is repaired. A raw uncorrectable word is replaced by a marked pattern that carries an error-mark identifier. A word that is already marked passes through unchanged.

The check code is a 72/64 single-error-correct, double-error-detect code. Check bits 6..0 are the XOR of the Hamming positions of the set data bits, where data bit j takes the (j+1)-th position in 3..127 that is not a power of two. Check bit 7 makes the parity of all 72 bits even. A marked word has data bits 11..0 equal to the identifier and all higher data bits zero. Its check bits equal the generated check bits of that data XOR 8'hFF. A raw detection raises a sticky, non-fatal status flag. Software clears the flag with a write-one-to-clear strobe.

Control is a two-state machine. ST_IDLE waits for the first beat of a line. When that beat is accepted it latches the identifier and moves to ST_BURST. ST_BURST counts the accepted beats. When the eighth beat is accepted it returns to ST_IDLE and pulses the line-done output for one cycle.

Top module: `wb_ue_marker`

## Requirements
- R1: A beat whose check bits equal the generated check bits of its data is forwarded with data and check bits unchanged.
- R2: A beat whose check bits equal the generated check bits XOR 8'hFF (a marked word) is forwarded with data and check bits unchanged, and does not set the status flag.
- R3: Any other beat whose error is not a single-bit error is a raw error. It is forwarded with data = {52'b0, id} and check = generated(data) XOR 8'hFF, where id is the identifier in force for the line.
- R4: Every forwarded word is either clean (check = generated) or marked (check = generated XOR 8'hFF).
- R5: Acceptance of a raw beat sets `raw_ue_flag` on the next cycle.
- R6: A single-bit error in any of the 72 bits is corrected. The corrected data goes out with regenerated check bits, and the flag is not set.
- R7: `raw_ue_flag` stays set until a cycle with `stat_clr` high. If a raw beat is accepted in the same cycle as `stat_clr`, the flag stays set.
- R8: `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. A beat is accepted only in a cycle where both `in_valid` and `out_ready` are high.
- R9: `line_done` is high for exactly the one cycle that follows each eighth accepted beat of a line.
- R10: The identifier is sampled from `mark_id` when the first beat of a line is accepted. Later beats of that line use the sampled value even if `mark_id` changes.
- R11: After reset, `raw_ue_flag` and `line_done` are low and the next accepted beat is the first beat of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Writer offers a beat |
| in_ready | output | 1 | Unit can take the beat |
| in_data | input | 64 | Doubleword from the first-level cache |
| in_chk | input | 8 | Check bits of the doubleword |
| out_valid | output | 1 | Beat offered to second-level write port |
| out_ready | input | 1 | Second-level port accepts the beat |
| out_data | output | 64 | Doubleword to store |
| out_chk | output | 8 | Check bits to store |
| mark_id | input | 12 | Error-mark identifier register value |
| stat_clr | input | 1 | Write-one-to-clear strobe for the status flag |
| raw_ue_flag | output | 1 | Sticky raw uncorrectable-error status |
| line_done | output | 1 | One-cycle pulse after the eighth beat |

## Verification
The bench builds the unit with its default parameters: a 12-bit identifier and eight-beat lines on the 72/64 code. At these values the whole line length is reachable, so the eighth-beat wrap, a change of identifier in the middle of a line, and stalls on the last beat are all exercised. The bench finds correctable words by trying every one of the 72 single-bit flips, not by decoding the syndrome. This covers flips in data bits, in low check bits and in the overall parity bit. It also covers double errors, marked words, and a clear strobe that lands in the same cycle as a raw detection.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

    localparam int DW = 64;
    localparam int CW = 8;
    localparam int PW = CW - 1;
    localparam logic [CW-1:0] MARK_SYN = {CW{1'b1}};

    typedef enum logic [1:0] {
        CL_CLEAN  = 2'd0,
        CL_FIX    = 2'd1,
        CL_RAW    = 2'd2,
        CL_MARKED = 2'd3
    } word_class_e;

    // Hamming position taken by data bit j (non-powers of two from 3 upward)
    function automatic logic [PW-1:0] dpos(input int j);
        logic [PW-1:0] r;
        int            cnt;
        r   = '0;
        cnt = 0;
        for (int p = 3; p < (1 << PW); p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == j) r = PW'(p);
                cnt++;
            end
        end
        return r;
    endfunction

    function automatic logic [CW-1:0] ecc_gen(input logic [DW-1:0] d);
        logic [PW-1:0] c;
        c = '0;
        for (int j = 0; j < DW; j++) begin
            if (d[j]) c = c ^ dpos(j);
        end
        return {(^d) ^ (^c), c};
    endfunction

endpackage

// File: rtl/wbm_classify.sv
module wbm_classify
    import wbm_pkg::*;
#(
    parameter int ID_W = 12
) (
    input  logic [DW-1:0]   in_data,
    input  logic [CW-1:0]   in_chk,
    input  logic [ID_W-1:0] id,
    output logic [DW-1:0]   out_data,
    output logic [CW-1:0]   out_chk,
    output word_class_e     cls
);

    localparam int PAD_W = DW - ID_W;

    logic [CW-1:0] gen_c;
    logic [CW-1:0] syn;
    logic          par_odd;
    logic [DW-1:0] flip;
    logic          hit_data;
    logic          hit_chk;
    logic [DW-1:0] mark_d;

    assign gen_c   = ecc_gen(in_data);
    assign syn     = gen_c ^ in_chk;
    assign par_odd = (^in_data) ^ (^in_chk);
    assign mark_d  = {{PAD_W{1'b0}}, id};

    always_comb begin
        flip = '0;
        for (int j = 0; j < DW; j++) begin
            flip[j] = (dpos(j) == syn[PW-1:0]);
        end
    end

    assign hit_data = |flip;
    assign hit_chk  = $onehot0(syn[PW-1:0]);

    always_comb begin
        if (syn == '0) begin
            cls = CL_CLEAN;
        end else if (syn == MARK_SYN) begin
            cls = CL_MARKED;
        end else if (par_odd && (hit_data || hit_chk)) begin
            cls = CL_FIX;
        end else begin
            cls = CL_RAW;
        end
    end

    logic [DW-1:0] fixed_d;
    assign fixed_d = hit_chk ? in_data : (in_data ^ flip);

    always_comb begin
        unique case (cls)
            CL_CLEAN, CL_MARKED: begin
                out_data = in_data;
                out_chk  = in_chk;
            end
            CL_FIX: begin
                out_data = fixed_d;
                out_chk  = ecc_gen(fixed_d);
            end
            default: begin
                out_data = mark_d;
                out_chk  = ecc_gen(mark_d) ^ MARK_SYN;
            end
        endcase
    end

endmodule

// File: rtl/wbm_ctrl.sv
module wbm_ctrl #(
    parameter int ID_W  = 12,
    parameter int BEATS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [ID_W-1:0] mark_id,
    output logic [ID_W-1:0] id_use,
    output logic            line_done
);

    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } ctrl_state_e;

    ctrl_state_e     state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [ID_W-1:0]  id_hold;
    logic             done_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            id_hold   <= '0;
            line_done <= 1'b0;
        end else begin
            state     <= state_nx;
            cnt       <= cnt_nx;
            line_done <= done_nx;
            if (state == ST_IDLE && fire) id_hold <= mark_id;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        done_nx  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                id_use = mark_id;
                if (fire) begin
                    state_nx = ST_BURST;
                    cnt_nx   = CNT_W'(1);
                end
            end
            ST_BURST: begin
                id_use = id_hold;
                if (fire) begin
                    if (cnt == LAST) begin
                        state_nx = ST_IDLE;
                        cnt_nx   = '0;
                        done_nx  = 1'b1;
                    end else begin
                        cnt_nx = cnt + CNT_W'(1);
                    end
                end
            end
            default: id_use = mark_id;
        endcase
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    // R10
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !done_nx) |=> $stable(id_hold));

endmodule

// File: rtl/wbm_status.sv
module wbm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= set | (flag & ~clr);
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/wb_ue_marker.sv
module wb_ue_marker
    import wbm_pkg::*;
#(
    parameter int ID_W  = 12,
    parameter int BEATS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [63:0]     in_data,
    input  logic [7:0]      in_chk,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [63:0]     out_data,
    output logic [7:0]      out_chk,
    input  logic [ID_W-1:0] mark_id,
    input  logic            stat_clr,
    output logic            raw_ue_flag,
    output logic            line_done
);

    logic            fire;
    logic [ID_W-1:0] id_use;
    word_class_e     cls;

    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign fire      = in_valid & out_ready;

    wbm_ctrl #(.ID_W(ID_W), .BEATS(BEATS)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .mark_id   (mark_id),
        .id_use    (id_use),
        .line_done (line_done)
    );

    wbm_classify #(.ID_W(ID_W)) cls_i (
        .in_data  (in_data),
        .in_chk   (in_chk),
        .id       (id_use),
        .out_data (out_data),
        .out_chk  (out_chk),
        .cls      (cls)
    );

    wbm_status stat_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fire && cls == CL_RAW),
        .clr   (stat_clr),
        .flag  (raw_ue_flag)
    );

    // R4
    safe_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chk == ecc_gen(out_data) ||
                       out_chk == (ecc_gen(out_data) ^ MARK_SYN)));

    // R2
    marked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_chk == (ecc_gen(in_data) ^ MARK_SYN)) |->
            (out_data == in_data && out_chk == in_chk));

endmodule

// File: tb/wb_ue_marker_tb_top.sv
`timescale 1ns/1ps
module wb_ue_marker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic [7:0]  in_chk = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;
    logic [7:0]  out_chk;
    logic [11:0] mark_id = '0;
    logic        stat_clr = 1'b0;
    logic        raw_ue_flag;
    logic        line_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    wb_ue_marker dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_chk(in_chk),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_chk(out_chk),
        .mark_id(mark_id), .stat_clr(stat_clr),
        .raw_ue_flag(raw_ue_flag), .line_done(line_done)
    );

    // Reference code, built from the requirement text: column list of positions
    int col [64];
    initial begin
        int k;
        k = 0;
        for (int p = 3; k < 64; p++) begin
            if ((p & (p - 1)) != 0) begin
                col[k] = p;
                k++;
            end
        end
    end

    function automatic logic [7:0] ref_gen(input logic [63:0] d);
        int acc;
        int ones;
        acc  = 0;
        ones = 0;
        for (int j = 0; j < 64; j++) begin
            if (d[j]) begin
                acc  = acc ^ col[j];
                ones = ones + 1;
            end
        end
        for (int b = 0; b < 7; b++) if ((acc >> b) & 1) ones = ones + 1;
        return {ones[0], acc[6:0]};
    endfunction

    // Model state
    bit          m_flag = 0;
    bit          m_done = 0;
    int          m_cnt = 0;
    logic [11:0] m_id = '0;

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected output for one beat; cls: 0 clean,1 fix,2 raw,3 marked
    task automatic predict(input logic [63:0] d, input logic [7:0] c, input logic [11:0] id,
                           output logic [63:0] ed, output logic [7:0] ec, output int cls);
        logic [71:0] w;
        logic [71:0] t;
        logic [63:0] md;
        cls = 2;
        if (c == ref_gen(d)) cls = 0;
        else if (c == (ref_gen(d) ^ 8'hFF)) cls = 3;
        else begin
            w = {c, d};
            for (int i = 0; i < 72; i++) begin
                t = w;
                t[i] = ~t[i];
                if (t[71:64] == ref_gen(t[63:0])) begin
                    cls = 1;
                    ed  = t[63:0];
                    ec  = t[71:64];
                end
            end
        end
        if (cls == 0 || cls == 3) begin
            ed = d;
            ec = c;
        end else if (cls == 2) begin
            md = {52'b0, id};
            ed = md;
            ec = ref_gen(md) ^ 8'hFF;
        end
    endtask

    task automatic beat(input bit v, input bit r, input logic [63:0] d, input logic [7:0] c,
                        input bit clr, input logic [11:0] id);
        logic [63:0] ed;
        logic [7:0]  ec;
        int          cls;
        logic [11:0] id_now;
        bit          fire;
        string       tag;
        @(negedge clk);
        in_valid = v; out_ready = r; in_data = d; in_chk = c; stat_clr = clr; mark_id = id;
        #1;
        check(raw_ue_flag == m_flag, "R5 R7 flag", 72'(raw_ue_flag), 72'(m_flag));
        check(line_done == m_done, "R9 line_done", 72'(line_done), 72'(m_done));
        check(out_valid == v && in_ready == r, "R8 handshake",
              72'({out_valid, in_ready}), 72'({v, r}));
        id_now = (m_cnt == 0) ? id : m_id;
        predict(d, c, id_now, ed, ec, cls);
        if (v) begin
            case (cls)
                0: tag = "R1 clean";
                1: tag = "R6 corrected";
                2: tag = (m_cnt == 0) ? "R3 raw marked" : "R10 raw marked mid-line";
                default: tag = "R2 marked pass";
            endcase
            check(out_data == ed && out_chk == ec, tag, {out_chk, out_data}, {ec, ed});
            check(out_chk == ref_gen(out_data) || out_chk == (ref_gen(out_data) ^ 8'hFF),
                  "R4 safe word", {out_chk, out_data}, {ref_gen(out_data), out_data});
        end
        fire = v && r;
        @(posedge clk);
        m_flag = (fire && cls == 2) || (m_flag && !clr);
        m_done = 0;
        if (fire) begin
            if (m_cnt == 0) m_id = id;
            m_cnt++;
            if (m_cnt == 8) begin
                m_cnt  = 0;
                m_done = 1;
            end
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    // kind: 0 clean, 1 single flip, 2 double flip, 3 marked
    task automatic make(input int kind, output logic [63:0] d, output logic [7:0] c);
        logic [71:0] w;
        int a;
        int b;
        d = rnd64();
        if (kind == 3) begin
            d = {52'b0, 12'($urandom())};
            c = ref_gen(d) ^ 8'hFF;
        end else begin
            w = {ref_gen(d), d};
            a = $urandom_range(71, 0);
            b = (a + 1 + $urandom_range(70, 0)) % 72;
            if (kind >= 1) w[a] = ~w[a];
            if (kind == 2) w[b] = ~w[b];
            d = w[63:0];
            c = w[71:64];
        end
    endtask

    initial begin
        #150000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [7:0]  c;
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(raw_ue_flag == 1'b0 && line_done == 1'b0, "R11 reset outputs",
              72'({raw_ue_flag, line_done}), 72'(0));

        // Clean line
        for (int i = 0; i < 8; i++) begin make(0, d, c); beat(1, 1, d, c, 0, 12'h111); end
        // Single-bit errors, including every check-bit position
        for (int i = 0; i < 8; i++) begin
            d = rnd64(); c = ref_gen(d) ^ (8'h1 << i);
            beat(1, 1, d, c, 0, 12'h222);
        end
        for (int i = 0; i < 16; i++) begin make(1, d, c); beat(1, 1, d, c, 0, 12'h222); end
        // Marked words only: flag must stay low (R2)
        for (int i = 0; i < 8; i++) begin make(3, d, c); beat(1, 1, d, c, 0, 12'h333); end
        // Raw errors with identifier changing mid-line (R10)
        for (int i = 0; i < 8; i++) begin
            make(2, d, c);
            beat(1, 1, d, c, 0, 12'hA00 + 12'(i));
        end
        // Clear the flag alone (R7)
        beat(0, 1, '0, '0, 1, 12'h0);
        beat(0, 1, '0, '0, 0, 12'h0);
        // Raw beat offered under backpressure must not set flag (R8)
        make(2, d, c); beat(1, 0, d, c, 0, 12'h444);
        beat(1, 0, d, c, 0, 12'h444);
        // Clear in same cycle as accepted raw beat: detection wins (R7)
        beat(1, 1, d, c, 1, 12'h555);
        beat(0, 1, '0, '0, 0, 12'h0);
        // Mixed traffic with gaps and stalls
        for (int i = 0; i < 400; i++) begin
            make($urandom_range(3, 0), d, c);
            beat($urandom_range(3, 0) != 0, $urandom_range(3, 0) != 0, d, c,
                 $urandom_range(7, 0) == 0, 12'($urandom()));
        end
        beat(0, 1, '0, '0, 0, 12'h0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule